// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a register-mapped watchdog built around a 32-bit down-counter. It is accessed through a plain single-cycle read/write port. When the count runs out the first time, the block raises a pending interrupt and starts the count again from the load value. If that interrupt is still pending when the count runs out a second time, and the reset-enable bit is set, the block drives a reset request that stays high until its own reset input is applied.

Software keeps the watchdog alive in one of two ways. It can clear the interrupt, which also restarts the count, or it can write a fresh load value. All configuration writes go through a lock register. Writing the key value `0x1ACCE551` opens it, and writing any other value closes it again. The raw interrupt and the interrupt masked by the enable bit can both be read back.

The read data path can be combinational, or registered with one cycle of latency; the `RDATA_REG` parameter selects which.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the load register reads 0xFFFFFFFF, the count reads 0xFFFFFFFF, control reads 0, the lock reads 0 (unlocked), and both `irq` and `wdog_rst` are low.
- R2: The count decreases by one on each clock edge while control bit 0 (run) is 1. It holds its value while run is 0.
- R3: With run set and no interrupt pending, an edge that finds the count at 0 sets the raw interrupt and reloads the count from the load register. After a load write of L, the raw interrupt first reads 1 exactly L+1 edges after the write edge.
- R4: An edge that finds the count at 0 while the raw interrupt is pending and control bit 1 (reset enable) is 1 raises `wdog_rst`. After a load write of L this happens 2(L+1) edges after the write edge. `wdog_rst` then stays high, even if control is cleared, until `rst_n` is asserted.
- R5: When the reset-enable bit is 0, a second expiry with the interrupt pending does not raise `wdog_rst`. The count reloads and the interrupt stays pending.
- R6: Any write to offset 0x00C (interrupt clear) clears the raw interrupt and reloads the count from the load register. Reads of 0x00C return 0.
- R7: A write to offset 0x000 stores the load value and loads it into the count at once. A written value of 0 is stored as 1.
- R8: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and writing any other value there locks it. The lock register reads 1 when locked and 0 when unlocked. While locked, writes to load, control and interrupt clear have no effect.
- R9: Offset 0x014 bit 0 (masked status) and the `irq` output both equal the raw interrupt ANDed with the run bit. Offset 0x010 bit 0 is the raw interrupt.
- R10: Reads return the load at 0x000, the count at 0x004, control at 0x008 (bit 0 run, bit 1 reset enable), the status registers at 0x010 and 0x014, and the lock state at 0xC00. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq | output | 1 | Masked interrupt |
| wdog_rst | output | 1 | Sticky reset request |

## Verification
A write takes effect on the clock edge that samples it, so status and count reads are made at the following falling edge. Expiry timing is measured by counting edges from the load-write edge and comparing the count to L+1 for the interrupt and 2(L+1) for the reset, over a sweep of small load values. Every sample is taken at the falling edge, after all register updates have settled. The read path is combinational in the default configuration, so the bench reads without waiting an extra cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam logic [11:0] OFS_LOAD  = 12'h000;
   localparam logic [11:0] OFS_COUNT = 12'h004;
   localparam logic [11:0] OFS_CTRL  = 12'h008;
   localparam logic [11:0] OFS_ICLR  = 12'h00C;
   localparam logic [11:0] OFS_RAW   = 12'h010;
   localparam logic [11:0] OFS_MASK  = 12'h014;
   localparam logic [11:0] OFS_LOCK  = 12'hC00;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_LOAD, SEL_COUNT, SEL_CTRL,
      SEL_ICLR, SEL_RAW, SEL_MASK, SEL_LOCK
   } wd_reg_e;

   typedef struct packed {
      logic rst_en;
      logic run;
   } wd_ctrl_t;

   function automatic wd_reg_e wd_decode(input logic [11:0] a);
      case (a)
         OFS_LOAD:  return SEL_LOAD;
         OFS_COUNT: return SEL_COUNT;
         OFS_CTRL:  return SEL_CTRL;
         OFS_ICLR:  return SEL_ICLR;
         OFS_RAW:   return SEL_RAW;
         OFS_MASK:  return SEL_MASK;
         OFS_LOCK:  return SEL_LOCK;
         default:   return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          ADDR_W     = 12,
   parameter logic [31:0] UNLOCK_KEY = 32'h1ACCE551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output wd_reg_e           reg_id,
   output logic [DATA_W-1:0] load_q,
   output wd_ctrl_t          ctrl_q,
   output logic              lock_st,
   output logic              reload,
   output logic              clear,
   output logic [DATA_W-1:0] reload_val
);

   localparam logic [DATA_W-1:0] LOAD_INIT = '1;
   localparam logic [DATA_W-1:0] LOAD_MIN  = DATA_W'(1);

   logic hi_zero;
   generate
      if (ADDR_W > 12) begin : g_hi
         assign hi_zero = ~|addr[ADDR_W-1:12];
      end else begin : g_nohi
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign reg_id = hi_zero ? wd_decode(addr[11:0]) : SEL_NONE;

   logic wr_any, wr_cfg;
   logic [DATA_W-1:0] load_clamped;

   assign wr_any       = sel & we;
   assign wr_cfg       = wr_any & ~lock_st;
   assign load_clamped = (wdata == '0) ? LOAD_MIN : wdata;

   assign reload     = wr_cfg & ((reg_id == SEL_LOAD) | (reg_id == SEL_ICLR));
   assign clear      = wr_cfg & (reg_id == SEL_ICLR);
   assign reload_val = (reg_id == SEL_LOAD) ? load_clamped : load_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_st <= 1'b0;
         load_q  <= LOAD_INIT;
         ctrl_q  <= '0;
      end else begin
         if (wr_any && reg_id == SEL_LOCK)
            lock_st <= (wdata != DATA_W'(UNLOCK_KEY));
         if (wr_cfg && reg_id == SEL_LOAD)
            load_q <= load_clamped;
         if (wr_cfg && reg_id == SEL_CTRL)
            ctrl_q <= wd_ctrl_t'(wdata[1:0]);
      end
   end

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              rst_en,
   input  logic              reload,
   input  logic              clear,
   input  logic [DATA_W-1:0] reload_val,
   input  logic [DATA_W-1:0] load_q,
   output logic [DATA_W-1:0] cnt,
   output logic              raw,
   output logic              wd_rst
);

   localparam logic [DATA_W-1:0] CNT_INIT = '1;

   logic expired;
   assign expired = run & (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= CNT_INIT;
         raw    <= 1'b0;
         wd_rst <= 1'b0;
      end else if (reload) begin
         cnt <= reload_val;
         if (clear)
            raw <= 1'b0;
      end else if (expired) begin
         cnt <= load_q;
         if (!raw)
            raw <= 1'b1;
         else if (rst_en)
            wd_rst <= 1'b1;
      end else if (run) begin
         cnt <= cnt - DATA_W'(1);
      end
   end

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
   import wdog_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          ADDR_W     = 12,
   parameter logic [31:0] UNLOCK_KEY = 32'h1ACCE551,
   parameter bit          RDATA_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              wdog_rst
);

   generate
      if (DATA_W != 32) begin : g_bad_dw
         $error("wdog_twostage: DATA_W must be 32");
      end
      if (ADDR_W < 12) begin : g_bad_aw
         $error("wdog_twostage: ADDR_W must be at least 12");
      end
   endgenerate

   wd_reg_e           reg_id;
   logic [DATA_W-1:0] load_q, reload_val, cnt;
   wd_ctrl_t          ctrl_q;
   logic              lock_st, reload, clear, raw;

   wdog_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UNLOCK_KEY(UNLOCK_KEY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we),
      .addr(bus_addr), .wdata(bus_wdata), .reg_id(reg_id),
      .load_q(load_q), .ctrl_q(ctrl_q), .lock_st(lock_st),
      .reload(reload), .clear(clear), .reload_val(reload_val)
   );

   wdog_core #(.DATA_W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .rst_en(ctrl_q.rst_en),
      .reload(reload), .clear(clear), .reload_val(reload_val),
      .load_q(load_q), .cnt(cnt), .raw(raw), .wd_rst(wdog_rst)
   );

   logic masked;
   assign masked = raw & ctrl_q.run;
   assign irq    = masked;

   logic [DATA_W-1:0] rd_next;
   always_comb begin
      unique case (reg_id)
         SEL_LOAD:  rd_next = load_q;
         SEL_COUNT: rd_next = cnt;
         SEL_CTRL:  rd_next = DATA_W'(ctrl_q);
         SEL_RAW:   rd_next = DATA_W'(raw);
         SEL_MASK:  rd_next = DATA_W'(masked);
         SEL_LOCK:  rd_next = DATA_W'(lock_st);
         default:   rd_next = '0;
      endcase
   end

   generate
      if (RDATA_REG) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bus_rdata <= '0;
            else        bus_rdata <= rd_next;
         end
      end else begin : g_rd_comb
         assign bus_rdata = rd_next;
      end
   endgenerate

endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              lock_st,
   input logic [DATA_W-1:0] load_q,
   input logic [DATA_W-1:0] cnt,
   input logic              run,
   input logic              raw,
   input logic              irq,
   input logic              wdog_rst
);

   logic wr, hit_load, hit_iclr;
   assign wr       = bus_sel & bus_we;
   assign hit_load = (bus_addr == ADDR_W'(12'h000));
   assign hit_iclr = (bus_addr == ADDR_W'(12'h00C));

   // R4: the reset request is sticky
   assert_rst_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |=> wdog_rst);

   // R4: the reset request only rises after an interrupt was already pending
   assert_rst_after_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdog_rst) |-> $past(raw));

   // R9: no interrupt output without a raw interrupt
   assert_irq_needs_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> raw);

   // R8: locked writes leave the load register untouched
   assert_locked_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_st && wr && hit_load) |=> $stable(load_q));

   // R2: a stopped counter holds unless a reload write is accepted
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !(wr && !lock_st && (hit_load || hit_iclr))) |=> $stable(cnt));

   // R7: the load register never holds zero
   assert_load_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_q != '0);

endmodule

bind wdog_twostage wdog_twostage_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_addr(bus_addr), .lock_st(lock_st), .load_q(load_q), .cnt(cnt),
   .run(ctrl_q.run), .raw(raw), .irq(irq), .wdog_rst(wdog_rst)
);

// File: tb/sim_wdog_twostage.sv
module sim_wdog_twostage;

   localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
                           A_ICLR = 12'h00C, A_RAW = 12'h010, A_MASK = 12'h014,
                           A_LOCK = 12'hC00;
   localparam logic [31:0] KEY = 32'h1ACCE551;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, wdog_rst;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdog_twostage u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .wdog_rst(wdog_rst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the write edge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int first_raw, first_rst;
      do_reset();

      // R1 reset state
      rd(A_LOAD, v); chk("R1 load", v, 32'hFFFF_FFFF);
      rd(A_CNT, v);  chk("R1 count", v, 32'hFFFF_FFFF);
      rd(A_CTRL, v); chk("R1 ctrl", v, 0);
      rd(A_LOCK, v); chk("R1 lock", v, 0);
      chk("R1 irq", irq, 0);
      chk("R1 wdog_rst", wdog_rst, 0);
      edges(3);
      rd(A_CNT, v);  chk("R2 stopped count holds", v, 32'hFFFF_FFFF);

      // R2 decrement then hold
      wr(A_CTRL, 1);
      wr(A_LOAD, 100);
      rd(A_CNT, v);  chk("R7 load write reloads count", v, 100);
      edges(10);
      rd(A_CNT, v);  chk("R2 count after 10 edges", v, 90);
      wr(A_CTRL, 0);
      edges(5);
      rd(A_CNT, v);  chk("R2 count holds after stop", v, 89);

      // R3 and R4 sweep over small load values
      for (int L = 1; L <= 6; L++) begin
         do_reset();
         wr(A_CTRL, 3);
         wr(A_LOAD, L);
         first_raw = 0; first_rst = 0;
         for (int k = 1; k <= 2 * L + 5; k++) begin
            edges(1);
            rd(A_RAW, v);
            if (v[0] && first_raw == 0) first_raw = k;
            if (wdog_rst && first_rst == 0) first_rst = k;
         end
         chk("R3 edges to interrupt", first_raw, L + 1);
         chk("R4 edges to reset", first_rst, 2 * L + 2);
      end
      wr(A_CTRL, 0);
      wr(A_ICLR, 0);
      edges(2);
      chk("R4 reset sticky", wdog_rst, 1);
      do_reset();
      chk("R4 reset cleared by rst_n", wdog_rst, 0);

      // R5 no reset when reset enable is clear
      wr(A_CTRL, 1);
      wr(A_LOAD, 3);
      edges(8);
      chk("R5 no reset", wdog_rst, 0);
      rd(A_RAW, v);  chk("R5 interrupt pending", v, 1);
      rd(A_CNT, v);  chk("R5 count reloaded", v, 3);

      // R6 interrupt clear and R9 masking
      do_reset();
      wr(A_CTRL, 1);
      wr(A_LOAD, 4);
      edges(5);
      rd(A_RAW, v);  chk("R3 raw set", v, 1);
      rd(A_MASK, v); chk("R9 masked set", v, 1);
      chk("R9 irq high", irq, 1);
      edges(2);
      wr(A_ICLR, 32'hDEAD);
      rd(A_RAW, v);  chk("R6 raw cleared", v, 0);
      rd(A_CNT, v);  chk("R6 count reloaded", v, 4);
      chk("R6 irq low", irq, 0);
      rd(A_ICLR, v); chk("R6 clear reads 0", v, 0);
      edges(5);
      wr(A_CTRL, 0);
      rd(A_RAW, v);  chk("R9 raw stays", v, 1);
      rd(A_MASK, v); chk("R9 masked off", v, 0);
      chk("R9 irq masked", irq, 0);

      // R7 zero load stored as one
      wr(A_LOAD, 0);
      rd(A_LOAD, v); chk("R7 zero load", v, 1);
      rd(A_CNT, v);  chk("R7 zero load count", v, 1);

      // R8 lock
      wr(A_LOCK, 0);
      rd(A_LOCK, v); chk("R8 locked", v, 1);
      wr(A_LOAD, 77);
      rd(A_LOAD, v); chk("R8 load ignored", v, 1);
      wr(A_CTRL, 3);
      rd(A_CTRL, v); chk("R8 ctrl ignored", v, 0);
      wr(A_ICLR, 0);
      rd(A_RAW, v);  chk("R8 clear ignored", v, 1);
      wr(A_LOCK, KEY);
      rd(A_LOCK, v); chk("R8 unlocked", v, 0);
      wr(A_LOCK, 32'h1234_5678);
      rd(A_LOCK, v); chk("R8 other value locks", v, 1);
      wr(A_LOCK, KEY);
      wr(A_CTRL, 2);
      rd(A_CTRL, v); chk("R8 write after unlock", v, 2);

      // R10 unmapped offset
      rd(12'h020, v); chk("R10 unmapped reads 0", v, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule